// File: doc/BRIEF.md
# Patterned Line Rasterizer

The block turns a segment request, a start point and an end point on a framebuffer, into a stream of pixel coordinates. Coordinate (0,0) is the top-left pixel, X grows to the right and Y grows downward. Each accepted output cycle moves the position by one pixel along the dominant direction of the segment. An integer error accumulator decides when the other coordinate also moves by one. Only segments that run toward larger or equal X and Y are supported. A request that points the other way is refused with a one-cycle error flag and produces no pixels.

A 16-bit dash mask with a programmable repeat length gates each output pixel. A mask bit of 1 marks a pixel to paint. A mask bit of 0 produces a pixel slot with the write-enable low, and the coordinates still advance. A request is taken with a start pulse while the block is idle. Busy stays high while pixels are offered. Each pixel is a valid/ready transfer that a consumer can stall. Done pulses for one cycle after the last pixel is taken.

Top module: `line_draw_engine`

## Requirements
- R1: While reset is held, and after it is released, busy_o, pix_valid_o, done_o and err_o are all 0.
- R2: An accepted request produces exactly max(x1-x0, y1-y0)+1 pixel transfers. The first is at (x0,y0) and the last is at (x1,y1).
- R3: The dominant axis is X when x1-x0 >= y1-y0, so a tie selects X. Each accepted transfer moves the dominant coordinate by exactly +1.
- R4: With M the dominant delta and m the other delta, an accumulator e starts at 2m-M. On each advance, if e >= 0 the minor coordinate increments and e changes by 2m-2M. Otherwise e changes by 2m.
- R5: rep_len_i holds the repeat length minus one (0 means 1, 15 means 16). The dash index starts at 0 for the first pixel, increments on each advance, and wraps to 0 after reaching rep_len_i. pix_we_o is bit [index] of pattern_i.
- R6: A mask bit of 0 still produces a pixel transfer, with pix_we_o = 0, and the coordinates advance as in R3 and R4.
- R7: While pix_valid_o is 1 and ready_i is 0, pix_x_o, pix_y_o and pix_we_o hold their values and pix_valid_o stays 1.
- R8: done_o is 1 for exactly the one cycle after the final transfer. busy_o and pix_valid_o are 0 in that cycle.
- R9: A start with x1 < x0 or y1 < y0 produces err_o = 1 for exactly the next cycle and no pixel transfers.
- R10: A start pulse while busy_o is 1 is ignored, and the running segment continues unchanged.
- R11: A request with equal start and end points produces one transfer at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| x0_i | input | 12 | Start X |
| y0_i | input | 12 | Start Y |
| x1_i | input | 12 | End X |
| y1_i | input | 12 | End Y |
| pattern_i | input | 16 | Dash mask, bit 0 applies to the first pixel |
| rep_len_i | input | 4 | Repeat length minus one |
| ready_i | input | 1 | Consumer accepts the current pixel |
| busy_o | output | 1 | A segment is being drawn |
| done_o | output | 1 | One-cycle pulse after the final pixel |
| err_o | output | 1 | One-cycle pulse for a refused request |
| pix_valid_o | output | 1 | Pixel on the output is valid |
| pix_x_o | output | 12 | Pixel X |
| pix_y_o | output | 12 | Pixel Y |
| pix_we_o | output | 1 | Paint this pixel |

## Verification
The segments include a shallow slope, a steep slope and an exact diagonal tie. These show whether the dominant-axis choice and the accumulator sign test are right, including the >= comparison at zero. Horizontal, vertical and zero-length segments exercise the degenerate deltas and the transfer count. A long segment with a short repeat length and an irregular mask separates a correct index wrap from an off-by-one. A stalling consumer and a start pulse during drawing show that state holds under backpressure and that stray requests are dropped. Backward segments in X and in Y each confirm the refusal path.

// File: rtl/line_pkg.sv
// Shared definitions for the line rasterizer.
package line_pkg;
    localparam int unsigned PAT_W = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DRAW = 1'b1
    } draw_state_e;
endpackage

// File: rtl/line_setup.sv
// Combinational request decode: deltas, dominant axis, direction check,
// accumulator seeds. Assumes unsigned coordinates of CW bits.
module line_setup #(
    parameter int unsigned CW = 12,
    localparam int unsigned EW = CW + 2
) (
    input  logic [CW-1:0]        x0_i,
    input  logic [CW-1:0]        y0_i,
    input  logic [CW-1:0]        x1_i,
    input  logic [CW-1:0]        y1_i,
    output logic                 backward_o,
    output logic                 major_is_x_o,
    output logic [CW-1:0]        major_len_o,
    output logic signed [EW-1:0] err_init_o,
    output logic signed [EW-1:0] two_min_o,
    output logic signed [EW-1:0] two_diff_o
);
    logic [CW-1:0]        dx, dy, minor;
    logic signed [EW-1:0] two_maj, maj_ext;

    // Derive deltas, the dominant axis and the accumulator constants.
    always_comb begin
        backward_o   = (x1_i < x0_i) || (y1_i < y0_i);
        dx           = x1_i - x0_i;
        dy           = y1_i - y0_i;
        major_is_x_o = (dx >= dy);
        major_len_o  = major_is_x_o ? dx : dy;
        minor        = major_is_x_o ? dy : dx;
        two_min_o    = signed'({1'b0, minor, 1'b0});
        two_maj      = signed'({1'b0, major_len_o, 1'b0});
        maj_ext      = signed'({2'b00, major_len_o});
        err_init_o   = two_min_o - maj_ext;
        two_diff_o   = two_min_o - two_maj;
    end
endmodule

// File: rtl/line_stepper.sv
// Position and error accumulator. Loads a segment and moves one dominant
// step per advance. last_o flags the final pixel.
module line_stepper #(
    parameter int unsigned CW = 12,
    localparam int unsigned EW = CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 adv_i,
    input  logic [CW-1:0]        x0_i,
    input  logic [CW-1:0]        y0_i,
    input  logic                 major_is_x_i,
    input  logic [CW-1:0]        major_len_i,
    input  logic signed [EW-1:0] err_init_i,
    input  logic signed [EW-1:0] two_min_i,
    input  logic signed [EW-1:0] two_diff_i,
    output logic [CW-1:0]        x_o,
    output logic [CW-1:0]        y_o,
    output logic                 last_o
);
    logic [CW-1:0]        x_q, y_q, rem_q;
    logic signed [EW-1:0] err_q, two_min_q, two_diff_q;
    logic                 mx_q, minor_step;

    assign minor_step = (err_q >= 0);

    // Capture a new segment or advance the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q        <= '0;
            y_q        <= '0;
            rem_q      <= '0;
            err_q      <= '0;
            two_min_q  <= '0;
            two_diff_q <= '0;
            mx_q       <= 1'b1;
        end else if (load_i) begin
            x_q        <= x0_i;
            y_q        <= y0_i;
            rem_q      <= major_len_i;
            err_q      <= err_init_i;
            two_min_q  <= two_min_i;
            two_diff_q <= two_diff_i;
            mx_q       <= major_is_x_i;
        end else if (adv_i) begin
            rem_q <= rem_q - 1'b1;
            err_q <= err_q + (minor_step ? two_diff_q : two_min_q);
            if (mx_q || minor_step) x_q <= x_q + 1'b1;
            if (!mx_q || minor_step) y_q <= y_q + 1'b1;
        end
    end

    assign x_o    = x_q;
    assign y_o    = y_q;
    assign last_o = (rem_q == '0);
endmodule

// File: rtl/line_pattern.sv
// Dash mask sequencer: an index over the first LEN pattern bits that
// advances once per dominant step and wraps.
module line_pattern #(
    parameter int unsigned PW = line_pkg::PAT_W,
    localparam int unsigned IW = $clog2(PW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic [PW-1:0] pattern_i,
    input  logic [IW-1:0] rep_len_i,
    output logic          we_o
);
    logic [PW-1:0] pat_q;
    logic [IW-1:0] last_q, idx_q;

    // Latch the mask and step the index with wrap at the repeat length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q  <= '0;
            last_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            pat_q  <= pattern_i;
            last_q <= rep_len_i;
            idx_q  <= '0;
        end else if (adv_i) begin
            idx_q <= (idx_q == last_q) ? '0 : idx_q + 1'b1;
        end
    end

    assign we_o = pat_q[idx_q];
endmodule

// File: rtl/line_draw_engine.sv
// Top of the line rasterizer. Accepts a request while idle, refuses
// backward segments, streams pixels under valid/ready and pulses done.
module line_draw_engine #(
    parameter int unsigned CW = 12,
    parameter int unsigned PW = line_pkg::PAT_W,
    localparam int unsigned IW = $clog2(PW),
    localparam int unsigned EW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] x0_i,
    input  logic [CW-1:0] y0_i,
    input  logic [CW-1:0] x1_i,
    input  logic [CW-1:0] y1_i,
    input  logic [PW-1:0] pattern_i,
    input  logic [IW-1:0] rep_len_i,
    input  logic          ready_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          pix_valid_o,
    output logic [CW-1:0] pix_x_o,
    output logic [CW-1:0] pix_y_o,
    output logic          pix_we_o
);
    import line_pkg::*;

    draw_state_e          state_q;
    logic                 backward, major_is_x, last, load, adv;
    logic                 done_q, err_q;
    logic [CW-1:0]        major_len;
    logic signed [EW-1:0] err_init, two_min, two_diff;

    line_setup #(.CW(CW)) u_setup (
        .x0_i(x0_i), .y0_i(y0_i), .x1_i(x1_i), .y1_i(y1_i),
        .backward_o(backward), .major_is_x_o(major_is_x),
        .major_len_o(major_len), .err_init_o(err_init),
        .two_min_o(two_min), .two_diff_o(two_diff)
    );

    assign load = (state_q == ST_IDLE) && start_i && !backward;
    assign adv  = (state_q == ST_DRAW) && ready_i && !last;

    line_stepper #(.CW(CW)) u_step (
        .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
        .x0_i(x0_i), .y0_i(y0_i), .major_is_x_i(major_is_x),
        .major_len_i(major_len), .err_init_i(err_init),
        .two_min_i(two_min), .two_diff_i(two_diff),
        .x_o(pix_x_o), .y_o(pix_y_o), .last_o(last)
    );

    line_pattern #(.PW(PW)) u_pat (
        .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
        .pattern_i(pattern_i), .rep_len_i(rep_len_i), .we_o(pix_we_o)
    );

    // Control: take requests, finish segments, raise one-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i && backward) err_q <= 1'b1;
                    else if (start_i)        state_q <= ST_DRAW;
                end
                ST_DRAW: begin
                    if (ready_i && last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q == ST_DRAW);
    assign pix_valid_o = busy_o;
    assign done_o      = done_q;
    assign err_o       = err_q;
endmodule

// File: rtl/line_draw_checks.sv
// Port-level properties of the line rasterizer, attached by bind.
module line_draw_checks #(
    parameter int unsigned CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          ready_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic          pix_valid_o,
    input logic [CW-1:0] pix_x_o,
    input logic [CW-1:0] pix_y_o,
    input logic          pix_we_o
);
    localparam logic [CW-1:0] ONE = 1;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pix_valid_o);

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o && ready_i |=> !pix_valid_o ||
            (((pix_x_o - $past(pix_x_o)) <= ONE) &&
             ((pix_y_o - $past(pix_y_o)) <= ONE) &&
             ((pix_x_o != $past(pix_x_o)) || (pix_y_o != $past(pix_y_o)))));

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o && !ready_i |=> pix_valid_o && $stable(pix_x_o) &&
            $stable(pix_y_o) && $stable(pix_we_o));

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_valid_o) |-> done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pix_valid_o && !busy_o);

    assert_err_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(start_i) && !pix_valid_o);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o}));
endmodule

bind line_draw_engine line_draw_checks #(.CW(CW)) u_checks (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .pix_valid_o(pix_valid_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o),
    .pix_we_o(pix_we_o)
);

// File: tb/test_line_draw_engine.sv
// Scoreboard bench: the driver models each segment into a queue and the
// monitor compares every accepted pixel against it.
module test_line_draw_engine;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
    logic [15:0]   pattern = '0;
    logic [3:0]    rep_len = '0;
    logic          ready_r = 1'b1;
    logic          busy, done, err, pvalid, pwe;
    logic [CW-1:0] px, py;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    bit    stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [2*CW:0] exp_q[$];

    always #2 clk = ~clk;

    line_draw_engine i_line_draw_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .x0_i(x0), .y0_i(y0),
        .x1_i(x1), .y1_i(y1), .pattern_i(pattern), .rep_len_i(rep_len),
        .ready_i(ready_r), .busy_o(busy), .done_o(done), .err_o(err),
        .pix_valid_o(pvalid), .pix_x_o(px), .pix_y_o(py), .pix_we_o(pwe)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Monitor: compare each accepted pixel, then pick the next ready level.
    always @(negedge clk) begin
        if (rst_n && pvalid && ready_r) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected pixel", {px, py, pwe}, 0);
            end else begin
                logic [2*CW:0] e;
                e = exp_q.pop_front();
                check({px, py, pwe} == e, cur_tag, "pixel {x,y,we}", {px, py, pwe}, e);
            end
        end
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ready_r <= stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Driver: model the segment from the requirements, start it, await done.
    task automatic draw(input int ax, input int ay, input int bx, input int by,
                        input logic [15:0] pat, input int len, input string tag,
                        input bit inject);
        int dx, dy, maj, mnr, e, cx, cy, idx;
        bit mx;
        dx = bx - ax; dy = by - ay;
        mx = (dx >= dy);
        maj = mx ? dx : dy; mnr = mx ? dy : dx;
        e = 2 * mnr - maj; cx = ax; cy = ay; idx = 0;
        for (int i = 0; i <= maj; i++) begin
            exp_q.push_back({cx[CW-1:0], cy[CW-1:0], pat[idx]});
            if (e >= 0) begin
                if (mx) cy++; else cx++;
                e += 2 * mnr - 2 * maj;
            end else begin
                e += 2 * mnr;
            end
            if (mx) cx++; else cy++;
            idx = (idx == len) ? 0 : idx + 1;
        end
        cur_tag = tag;
        @(negedge clk);
        x0 = ax[CW-1:0]; y0 = ay[CW-1:0]; x1 = bx[CW-1:0]; y1 = by[CW-1:0];
        pattern = pat; rep_len = len[3:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            x0 = 1; y0 = 1; x1 = 2; y1 = 9; pattern = 16'h0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pixels left at done", exp_q.size(), 0);
        check(!busy && !pvalid, "R8", "busy/valid during done", {busy, pvalid}, 0);
        @(negedge clk);
        check(!done, "R8", "done width", done, 0);
    endtask

    task automatic refuse(input int ax, input int ay, input int bx, input int by);
        cur_tag = "R9";
        @(negedge clk);
        x0 = ax[CW-1:0]; y0 = ay[CW-1:0]; x1 = bx[CW-1:0]; y1 = by[CW-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err && !pvalid, "R9", "err pulse", {err, pvalid}, 2);
        @(negedge clk);
        check(!err, "R9", "err width", err, 0);
        repeat (4) begin
            @(negedge clk);
            check(!pvalid && !busy, "R9", "no pixels after refusal", {pvalid, busy}, 0);
        end
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        check(!busy && !pvalid && !done && !err, "R1", "outputs in reset",
              {busy, pvalid, done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !pvalid && !done && !err, "R1", "outputs after reset",
              {busy, pvalid, done, err}, 0);
        draw(0, 0, 4, 2, 16'hFFFF, 15, "R2", 0);
        draw(3, 1, 5, 9, 16'hA5A5, 15, "R4", 0);
        draw(2, 2, 7, 7, 16'h0001, 2, "R3", 0);
        draw(0, 5, 20, 5, 16'hFFFE, 0, "R6", 0);
        draw(7, 0, 7, 10, 16'h00F3, 4, "R5", 0);
        draw(9, 9, 9, 9, 16'h0001, 0, "R11", 0);
        draw(0, 0, 40, 17, 16'hF0F1, 15, "R10", 1);
        stall_en = 1'b1;
        draw(10, 3, 37, 29, 16'h3C5A, 6, "R7", 0);
        draw(0, 0, 30, 11, 16'h1234, 9, "R7", 0);
        stall_en = 1'b0;
        refuse(5, 0, 3, 4);
        refuse(0, 6, 4, 2);
        draw(4095, 0, 4095, 0, 16'h0001, 0, "R11", 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, cur_tag, "watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule